// File: doc/BRIEF.md
# Snooping Coherence Tracker for a Shared Lock Line

This block follows one cache line that holds a spin-lock word as it moves among a small set of processor caches joined by a snooping bus. Each processor's private copy is in one of five states: not present, Invalid, Shared, Exclusive or Modified. The block applies a MESI-style protocol to every request and reports the bus transaction that the request would cause. It also keeps the lock word itself. A test-and-set can then report both the coherence traffic it creates and whether it took the lock.

Requests arrive on a valid/ready stream. Each request carries a processor index, an opcode and, for stores, a write value. The tracker accepts one request per cycle. `req_ready` is low during reset and high from the first clock edge after reset is released, so a request is taken on any rising edge where `req_valid` and `req_ready` are both high. There is no further back-pressure. Each accepted request produces exactly one response beat one cycle later, and there is no ready on the response side. The current state of every cache is visible at all times on `line_state`.

Top module: `line_lock_tracker`

## Requirements
- R1: Reset state. All caches read not-present, the lock word is 0 and `rsp_valid` is low. The state encoding is 3 bits per cache, with cache i at bits [3i+2:3i]: 0 = not-present, 1 = Invalid, 2 = Shared, 3 = Exclusive, 4 = Modified.
- R2: A load from Invalid or not-present, when no other cache holds the line (Shared, Exclusive or Modified), installs the line in Exclusive with bus code 1 (read). Bus codes: 0 = none, 1 = read, 2 = read-for-ownership, 3 = upgrade.
- R3: A load from Invalid or not-present, when another cache holds the line, issues bus code 1. The requester ends in Shared, and every other holder, including an Exclusive or Modified one, ends in Shared.
- R4: A load that hits (Shared, Exclusive or Modified), and a store or test-and-set that hits in Modified, issue bus code 0 and change no state. Opcodes: 0 = load, 1 = store, 2 = test-and-set, 3 = reserved.
- R5: A store or test-and-set from Exclusive moves the requester to Modified with bus code 0.
- R6: A store or test-and-set from Shared issues bus code 3. The requester goes to Modified and every other Shared copy goes to Invalid.
- R7: A store or test-and-set from Invalid or not-present issues bus code 2. The requester goes to Modified, every other holder goes to Invalid, and caches that were Invalid or not-present keep their state.
- R8: A test-and-set returns the old lock word on `rsp_data` and writes 1. `rsp_acq` is 1 only when the old word was 0. The coherence effect is that of a write even when the lock is already held.
- R9: A load returns the lock word unchanged. A store returns the old word and writes `req_wdata`; a store of 0 is the unlock.
- R10: A request with an index of 3 or more, or with opcode 3, is answered with `rsp_bad` = 1, bus code 0, `rsp_data` = 0 and `rsp_acq` = 0. No cache state and no lock word change.
- R11: `req_ready` is high from the first edge after reset. Each accepted request gives one `rsp_valid` beat on the next cycle, and `rsp_valid` stays low in cycles that follow no accepted request.
- R12: At most one cache is Exclusive or Modified. While one is, no other cache is Shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Tracker can take a request |
| req_idx | input | 2 | Requesting processor index |
| req_op | input | 2 | Opcode: 0 load, 1 store, 2 test-and-set, 3 reserved |
| req_wdata | input | 8 | Value written by a store |
| rsp_valid | output | 1 | Response beat for the request accepted one cycle earlier |
| rsp_bus | output | 2 | Bus transaction: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| rsp_data | output | 8 | Lock word before the access |
| rsp_acq | output | 1 | Test-and-set took the lock |
| rsp_bad | output | 1 | Request was rejected and ignored |
| line_state | output | 9 | Current per-cache state, 3 bits per cache |

## Verification
A request accepted at a rising edge updates the cache states, the lock word and all response fields on that same edge. Every result is therefore due exactly one cycle after acceptance. The bench drives each request on a falling edge and checks both the response fields and `line_state` on the next falling edge, halfway after the accepting edge. It checks `rsp_valid` low on the falling edge after each inserted idle cycle. A rejected request is confirmed harmless because `line_state` is compared in the same sample and the lock word is read back by later loads.

// File: rtl/llt_pkg.sv
package llt_pkg;
  typedef enum logic [2:0] {
    ST_NP = 3'd0, ST_I = 3'd1, ST_S = 3'd2, ST_E = 3'd3, ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0, BUS_RD = 2'd1, BUS_RDX = 2'd2, BUS_UPGR = 2'd3
  } bus_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_TAS = 2'd2, OP_RSVD = 2'd3
  } op_e;

  function automatic logic holds_line(line_st_e s);
    return (s == ST_S) || (s == ST_E) || (s == ST_M);
  endfunction
endpackage

// File: rtl/llt_bus_select.sv
module llt_bus_select
  import llt_pkg::*;
(
  input  line_st_e own_st,
  input  op_e      op,
  input  logic     others_hold,
  output bus_e     bus,
  output line_st_e own_next
);
  always_comb begin
    bus      = BUS_NONE;
    own_next = own_st;
    if (op == OP_LOAD) begin
      if (!holds_line(own_st)) begin
        bus      = BUS_RD;
        own_next = others_hold ? ST_S : ST_E;
      end
    end else if (op == OP_STORE || op == OP_TAS) begin
      own_next = ST_M;
      unique case (own_st)
        ST_M, ST_E: bus = BUS_NONE;
        ST_S:       bus = BUS_UPGR;
        default:    bus = BUS_RDX;
      endcase
    end
  end
endmodule

// File: rtl/llt_snoop_cell.sv
module llt_snoop_cell
  import llt_pkg::*;
(
  input  line_st_e cur,
  input  bus_e     bus,
  output line_st_e nxt
);
  always_comb begin
    nxt = cur;
    if (holds_line(cur)) begin
      unique case (bus)
        BUS_RD:            nxt = ST_S;
        BUS_RDX, BUS_UPGR: nxt = ST_I;
        default:           nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/llt_lock_word.sv
module llt_lock_word #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_val,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (wr_en) word <= wr_val;
  end
endmodule

// File: rtl/line_lock_tracker.sv
module line_lock_tracker
  import llt_pkg::*;
#(
  parameter int NUM_CPU = 3,
  parameter int WORD_W  = 8,
  localparam int IDX_W  = $clog2(NUM_CPU + 1),
  localparam int ST_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [IDX_W-1:0]        req_idx,
  input  logic [1:0]              req_op,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_bus,
  output logic [WORD_W-1:0]       rsp_data,
  output logic                    rsp_acq,
  output logic                    rsp_bad,
  output logic [NUM_CPU*ST_W-1:0] line_state
);
  line_st_e          st_q    [NUM_CPU];
  line_st_e          snoop_d [NUM_CPU];
  logic              ready_q;
  logic              fire, idx_ok, op_ok, act;
  op_e               op;
  line_st_e          own_st, own_next;
  logic              others_hold;
  bus_e              sel_bus, bus_eff;
  logic [WORD_W-1:0] word_q;
  logic [NUM_CPU-1:0] excl_vec, share_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  assign fire   = req_valid && ready_q;
  assign op     = op_e'(req_op);
  assign idx_ok = req_idx < IDX_W'(NUM_CPU);
  assign op_ok  = op != OP_RSVD;
  assign act    = fire && idx_ok && op_ok;

  // requester view and presence of copies elsewhere
  always_comb begin
    own_st      = ST_NP;
    others_hold = 1'b0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (IDX_W'(i) == req_idx) own_st = st_q[i];
      else if (holds_line(st_q[i])) others_hold = 1'b1;
    end
  end

  llt_bus_select u_sel (
    .own_st      (own_st),
    .op          (op),
    .others_hold (others_hold),
    .bus         (sel_bus),
    .own_next    (own_next)
  );

  assign bus_eff = act ? sel_bus : BUS_NONE;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cache
    llt_snoop_cell u_cell (
      .cur (st_q[g]),
      .bus (bus_eff),
      .nxt (snoop_d[g])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)                             st_q[g] <= ST_NP;
      else if (act && req_idx == IDX_W'(g))   st_q[g] <= own_next;
      else                                    st_q[g] <= snoop_d[g];
    end
    assign line_state[g*ST_W +: ST_W] = st_q[g];
    assign excl_vec[g]  = (st_q[g] == ST_E) || (st_q[g] == ST_M);
    assign share_vec[g] = st_q[g] == ST_S;
  end

  llt_lock_word #(.WORD_W(WORD_W)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (act && op != OP_LOAD),
    .wr_val ((op == OP_TAS) ? WORD_W'(1) : req_wdata),
    .word   (word_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bus   <= BUS_NONE;
      rsp_data  <= '0;
      rsp_acq   <= 1'b0;
      rsp_bad   <= 1'b0;
    end else begin
      rsp_valid <= fire;
      rsp_bus   <= bus_eff;
      rsp_data  <= act ? word_q : '0;
      rsp_acq   <= act && op == OP_TAS && word_q == '0;
      rsp_bad   <= fire && !(idx_ok && op_ok);
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(excl_vec) <= 1); // R12
  AST_OWNER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (excl_vec != '0) |-> (share_vec == '0)); // R12
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bad) |-> (rsp_bus == BUS_NONE && !rsp_acq)); // R10
  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(idx_ok && op_ok)) |=> $stable(line_state) && $stable(word_q)); // R10
  AST_WRITE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (act && op != OP_LOAD) |=> (st_q[$past(req_idx)] == ST_M)); // R7
  AST_ACQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_acq) |-> (word_q == WORD_W'(1))); // R8
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R11
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !req_valid) |=> !rsp_valid); // R11
endmodule

// File: tb/line_lock_tracker_tb.sv
module line_lock_tracker_tb_top;
  localparam int CLK_P = 10;
  localparam int NCPU  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_idx = '0;
  logic [1:0] req_op = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [1:0] rsp_bus;
  logic [7:0] rsp_data;
  logic       rsp_acq, rsp_bad;
  logic [8:0] line_state;

  int errors = 0;
  int checks = 0;
  int es [NCPU];
  int eword = 0;

  line_lock_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_op(req_op), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_bus(rsp_bus), .rsp_data(rsp_data),
    .rsp_acq(rsp_acq), .rsp_bad(rsp_bad), .line_state(line_state)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit holds(int s);
    return s == 2 || s == 3 || s == 4;
  endfunction

  function automatic int pack_states();
    int v = 0;
    for (int i = 0; i < NCPU; i++) v |= es[i] << (3 * i);
    return v;
  endfunction

  task automatic check_owner_rule();
    int nex = 0;
    int nsh = 0;
    for (int i = 0; i < NCPU; i++) begin
      int s = (line_state >> (3 * i)) & 7;
      if (s == 3 || s == 4) nex++;
      if (s == 2) nsh++;
    end
    chk((nex > 1 || (nex == 1 && nsh > 0)) ? 1 : 0, 0, "R12", "single owner");
  endtask

  // entered at a falling edge; leaves at the falling edge where the response is sampled
  task automatic issue(input int op, input int idx, input int wd);
    int exp_bus = 0, exp_data = 0, exp_acq = 0, exp_bad = 0;
    string tag, dtag;
    req_valid = 1'b1; req_op = 2'(op); req_idx = 2'(idx); req_wdata = 8'(wd);
    if (idx >= NCPU || op == 3) begin
      exp_bad = 1; tag = "R10"; dtag = "R10";
    end else begin
      int own = es[idx];
      bit oh = 1'b0;
      for (int j = 0; j < NCPU; j++) if (j != idx && holds(es[j])) oh = 1'b1;
      dtag = (op == 2) ? "R8" : "R9";
      exp_data = eword;
      if (op == 0) begin
        if (holds(own)) tag = "R4";
        else begin
          exp_bus = 1;
          tag = oh ? "R3" : "R2";
          for (int j = 0; j < NCPU; j++) if (j != idx && holds(es[j])) es[j] = 2;
          es[idx] = oh ? 2 : 3;
        end
      end else begin
        if (own == 4) tag = "R4";
        else if (own == 3) tag = "R5";
        else if (own == 2) begin
          exp_bus = 3; tag = "R6";
        end else begin
          exp_bus = 2; tag = "R7";
        end
        if (exp_bus != 0)
          for (int j = 0; j < NCPU; j++) if (j != idx && holds(es[j])) es[j] = 1;
        es[idx] = 4;
        if (op == 2) begin
          exp_acq = (eword == 0) ? 1 : 0;
          eword = 1;
        end else eword = wd;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(int'(rsp_valid), 1, "R11", "rsp_valid");
    chk(int'(rsp_bus), exp_bus, tag, "bus");
    chk(int'(line_state), pack_states(), tag, "states");
    chk(int'(rsp_data), exp_data, dtag, "data");
    chk(int'(rsp_acq), exp_acq, dtag, "acq");
    chk(int'(rsp_bad), exp_bad, "R10", "bad flag");
    check_owner_rule();
  endtask

  task automatic idle();
    @(negedge clk);
    chk(int'(rsp_valid), 0, "R11", "idle rsp_valid");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < NCPU; i++) es[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(line_state), 0, "R1", "reset states");
    chk(int'(rsp_valid), 0, "R1", "reset rsp_valid");
    chk(int'(req_ready), 1, "R11", "ready after reset");

    // two-level spin lock handoff sequence, ops: 0 load, 1 store, 2 tas
    issue(0, 0, 0); issue(2, 0, 0); issue(0, 1, 0); issue(0, 2, 0);
    issue(0, 1, 0); issue(1, 0, 0); issue(0, 1, 0); issue(2, 1, 0);
    issue(2, 2, 0);                     // held: R8 write effect, no acquire
    issue(0, 2, 0); issue(1, 1, 0); issue(0, 2, 0); issue(2, 2, 0);
    issue(1, 2, 0); idle();
    issue(0, 3, 0); issue(3, 1, 0);     // rejected: R10
    issue(0, 1, 0);                     // word unchanged after rejects

    // pseudo-random sweep across all opcode/index codes
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(int'(lfsr[3:2]), int'(lfsr[1:0]), lfsr[9] ? int'(lfsr[15:8]) : 0);
      if (lfsr[6:4] == 3'd0) idle();
    end
    finish_run();
  end
endmodule